// File: doc/BRIEF.md
# BCD Clock-Calendar Counter with Half-Minute Rounding

This block keeps wall-clock time and calendar date as packed BCD nibbles. It covers seconds, minutes, 24-hour hours, a 3-bit weekday, date, month and a year from 0000 to 3999. A single system clock runs the logic. The input `ref_tick` is a one-cycle enable that arrives once per period of a 32.768 kHz reference. A sub-second divider counts those ticks and moves the seconds forward once every `TICKS_PER_SEC` ticks. Each carry ripples through minutes, hours, weekday, date, month and year. The carry follows month lengths and a divisible-by-four leap-year rule.

Software reaches the block through a 16-entry nibble port. Each address maps to one BCD digit, and the last address is a control nibble. In that nibble, one bit freezes the divider and holds it cleared. A second bit is a write-only rounding command that snaps the seconds to the nearest whole minute. The same bit reads back as a busy indicator. Busy covers the last `BUSY_TICKS` reference ticks before every seconds update, and also any rounding command still waiting to run. A sticky oscillator-fail flag shares a nibble with the seconds tens digit.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read 2000-01-01, weekday 0, 00:00:00. The fail flag reads 1, and the control nibble reads 0000.
- R2: Seconds advance in BCD once every `TICKS_PER_SEC` accepted reference ticks. Seconds 59 wrap to 00 and step the minutes. Minutes 59 wrap to 00 and step the hours. Hours 23 wrap to 00 and step both the date and the weekday.
- R3: The weekday (address 6, bits 2:0) counts 0 to 6 and wraps from 6 to 0 at midnight.
- R4: Months 04, 06, 09 and 11 end on day 30, and other months except 02 end on day 31. February ends on day 28 in a non-leap year. At the end of a month the date goes to 01 and the month steps, and month 12 wraps to 01.
- R5: A year whose two low BCD digits form a multiple of 4 is a leap year, and its February ends on day 29.
- R6: The year is four BCD digits at addresses B (ones), C (tens), D (hundreds) and E (thousands, bits 1:0). December 31 at 23:59:59 rolls to January 01 of the next year, so 2099 becomes 2100.
- R7: Writing 1 to control bit 0 (address F) while the seconds are 00 to 29 clears the seconds and leaves the minutes unchanged. The command runs on the next reference tick, even when the clock is stopped.
- R8: The same command with seconds at 30 to 59 clears the seconds and steps the minutes, with full carry through every higher field.
- R9: The command clears itself within one reference tick. Writing 0 to that bit has no effect. While the command waits, bit 0 of address F reads 1.
- R10: Bit 0 of address F reads 1 for the last `BUSY_TICKS` reference ticks of each second. The seconds update on the tick that closes that window.
- R11: Writing 1 to control bit 1 (address F) stops the seconds and holds the divider at zero. Writing 0 resumes counting, and the first update comes a full `TICKS_PER_SEC` ticks later. Bit 1 reads back as written.
- R12: When a waiting rounding command and a seconds carry fall on the same reference tick, only the rounding is applied.
- R13: The fail flag (address 1, bit 3) is set by `osc_stop` and stays 1 until software writes 0. The input has priority over a write in the same cycle.
- R14: Bits that do not exist in a field read 0. For example, address 5 holds only hour-tens bits 1:0, address E holds only bits 1:0, and bits 3:2 of address F read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| osc_stop | input | 1 | Pulse from the oscillator-stop detector; sets the fail flag |
| bus_we | input | 1 | Write strobe for the nibble port |
| bus_addr | input | 4 | Nibble address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data of the addressed nibble (combinational) |

## Verification
The rounding command and the ordinary seconds carry can land on the same reference tick. To provoke this, the bench sets 08:10:59, releases the divider, and counts reference ticks from the release. It then writes the rounding bit in the cycle right after the second-to-last tick of that second, so the command runs on the tick that would also carry the seconds. The expected result is 08:11:00: a single minute step, with no extra second and no double minute increment.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [1:0]      yr_k;
    logic [2:0][3:0] yr;
    logic            mon_t;
    logic [3:0]      mon_o;
    logic [1:0]      day_t;
    logic [3:0]      day_o;
    logic [2:0]      wday;
    logic [1:0]      hr_t;
    logic [3:0]      hr_o;
    logic [2:0]      min_t;
    logic [3:0]      min_o;
    logic [2:0]      sec_t;
    logic [3:0]      sec_o;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{
    yr_k: 2'd2, yr: '0, mon_t: 1'b0, mon_o: 4'd1, day_t: 2'd0, day_o: 4'd1,
    wday: 3'd0, hr_t: 2'd0, hr_o: 4'd0, min_t: 3'd0, min_o: 4'd0,
    sec_t: 3'd0, sec_o: 4'd0};

  localparam logic [3:0] CTL_ADDR = 4'hF;

  // one BCD digit step: bit 4 is the carry out, bits 3:0 the new digit
  function automatic logic [4:0] dig_step(input logic [3:0] d, input logic [3:0] lim);
    if (d >= lim) return 5'b1_0000;
    return {1'b0, d + 4'd1};
  endfunction

  // two-digit BCD year divisible by four: (10*t + o) mod 4 == (2*t + o) mod 4
  function automatic logic leap_year(input logic [3:0] ones, input logic [3:0] tens);
    logic [3:0] s;
    s = ones + {2'b00, tens[0], 1'b0};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic mt, input logic [3:0] mo,
                                            input logic lp);
    if (!mt && mo == 4'd2) return lp ? 8'h29 : 8'h28;
    if ((!mt && (mo == 4'd4 || mo == 4'd6 || mo == 4'd9)) || (mt && mo == 4'd1))
      return 8'h30;
    return 8'h31;
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic ctl_wr,
  input  logic [3:0] ctl_data,
  output logic sec_pulse,
  output logic adj_fire,
  output logic adj_pend,
  output logic stop_q,
  output logic busy
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WIN_START = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] div_q, div_d;
  logic          div_en;
  logic          stop_d, adj_d;
  logic          at_last;

  always_comb begin
    at_last   = (div_q == LAST);
    adj_fire  = ref_tick & adj_pend;
    sec_pulse = ref_tick & ~stop_q & ~adj_pend & at_last;
    div_en    = stop_q | adj_fire | ref_tick;
    if (stop_q || adj_fire)  div_d = '0;
    else if (at_last)        div_d = '0;
    else                     div_d = div_q + CW'(1);
    stop_d = ctl_wr ? ctl_data[1] : stop_q;
    if (ctl_wr && ctl_data[0]) adj_d = 1'b1;
    else if (adj_fire)         adj_d = 1'b0;
    else                       adj_d = adj_pend;
    busy = adj_pend | (~stop_q & (div_q >= WIN_START));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      stop_q   <= 1'b0;
      adj_pend <= 1'b0;
    end else begin
      if (div_en) div_q <= div_d;
      stop_q   <= stop_d;
      adj_pend <= adj_d;
    end
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_pulse,
  input  logic      adj_fire,
  input  logic      osc_stop,
  input  logic      wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  output rtc_time_t cur,
  output logic      fail_q
);
  rtc_time_t  nx;
  logic       nx_fail, upd_en;
  logic [4:0] s0, s1, m0, m1, h0, d0, y_r;
  logic [7:0] last_day;
  logic       min_step, hr_step, day_step, mon_step, yr_step, ycar;

  always_comb begin
    nx       = cur;
    nx_fail  = fail_q;
    min_step = 1'b0;
    hr_step  = 1'b0;
    day_step = 1'b0;
    mon_step = 1'b0;
    yr_step  = 1'b0;
    s0 = dig_step(cur.sec_o, 4'd9);
    s1 = dig_step({1'b0, cur.sec_t}, 4'd5);
    m0 = dig_step(cur.min_o, 4'd9);
    m1 = dig_step({1'b0, cur.min_t}, 4'd5);
    h0 = dig_step(cur.hr_o, 4'd9);
    d0 = dig_step(cur.day_o, 4'd9);
    y_r = 5'd0;
    last_day = month_last(cur.mon_t, cur.mon_o, leap_year(cur.yr[0], cur.yr[1]));

    // seconds: rounding command overrides the ordinary carry
    if (adj_fire) begin
      nx.sec_o = 4'd0;
      nx.sec_t = 3'd0;
      min_step = (cur.sec_t >= 3'd3);
    end else if (sec_pulse) begin
      nx.sec_o = s0[3:0];
      if (s0[4]) begin
        nx.sec_t = s1[2:0];
        min_step = s1[4];
      end
    end

    if (min_step) begin
      nx.min_o = m0[3:0];
      if (m0[4]) begin
        nx.min_t = m1[2:0];
        hr_step  = m1[4];
      end
    end

    if (hr_step) begin
      if ({2'b00, cur.hr_t, cur.hr_o} >= 8'h23) begin
        nx.hr_t  = 2'd0;
        nx.hr_o  = 4'd0;
        day_step = 1'b1;
      end else begin
        nx.hr_o = h0[3:0];
        if (h0[4]) nx.hr_t = cur.hr_t + 2'd1;
      end
    end

    if (day_step) begin
      nx.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      if ({2'b00, cur.day_t, cur.day_o} >= last_day) begin
        nx.day_t = 2'd0;
        nx.day_o = 4'd1;
        mon_step = 1'b1;
      end else begin
        nx.day_o = d0[3:0];
        if (d0[4]) nx.day_t = cur.day_t + 2'd1;
      end
    end

    if (mon_step) begin
      if ({3'b000, cur.mon_t, cur.mon_o} >= 8'h12) begin
        nx.mon_t = 1'b0;
        nx.mon_o = 4'd1;
        yr_step  = 1'b1;
      end else if (cur.mon_o >= 4'd9) begin
        nx.mon_o = 4'd0;
        nx.mon_t = 1'b1;
      end else begin
        nx.mon_o = cur.mon_o + 4'd1;
      end
    end

    ycar = yr_step;
    for (int i = 0; i < 3; i++) begin
      y_r = dig_step(cur.yr[i], 4'd9);
      if (ycar) begin
        nx.yr[i] = y_r[3:0];
        ycar     = y_r[4];
      end
    end
    if (ycar) nx.yr_k = cur.yr_k + 2'd1;

    if (wr_en) begin
      case (wr_addr)
        4'h0: nx.sec_o = wr_data;
        4'h1: begin nx.sec_t = wr_data[2:0]; nx_fail = wr_data[3]; end
        4'h2: nx.min_o = wr_data;
        4'h3: nx.min_t = wr_data[2:0];
        4'h4: nx.hr_o  = wr_data;
        4'h5: nx.hr_t  = wr_data[1:0];
        4'h6: nx.wday  = wr_data[2:0];
        4'h7: nx.day_o = wr_data;
        4'h8: nx.day_t = wr_data[1:0];
        4'h9: nx.mon_o = wr_data;
        4'hA: nx.mon_t = wr_data[0];
        4'hB: nx.yr[0] = wr_data;
        4'hC: nx.yr[1] = wr_data;
        4'hD: nx.yr[2] = wr_data;
        4'hE: nx.yr_k  = wr_data[1:0];
        default: ;
      endcase
    end

    if (osc_stop) nx_fail = 1'b1;
    upd_en = sec_pulse | adj_fire | wr_en | osc_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= RTC_RESET;
      fail_q <= 1'b1;
    end else if (upd_en) begin
      cur    <= nx;
      fail_q <= nx_fail;
    end
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       osc_stop,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       ctl_wr, fld_wr;
  logic       sec_pulse, adj_fire, adj_pend, stop_q, busy, fail_q;
  rtc_time_t  t_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign ctl_wr = bus_we & (bus_addr == CTL_ADDR);
  assign fld_wr = bus_we & (bus_addr != CTL_ADDR);

  rtc_tick_gen #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .BUSY_TICKS   (BUSY_TICKS)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ref_tick (ref_tick),
    .ctl_wr   (ctl_wr),
    .ctl_data (bus_wdata),
    .sec_pulse(sec_pulse),
    .adj_fire (adj_fire),
    .adj_pend (adj_pend),
    .stop_q   (stop_q),
    .busy     (busy)
  );

  rtc_time_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sec_pulse(sec_pulse),
    .adj_fire (adj_fire),
    .osc_stop (osc_stop),
    .wr_en    (fld_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .cur      (t_now),
    .fail_q   (fail_q)
  );

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = t_now.sec_o;
      4'h1:    bus_rdata = {fail_q, t_now.sec_t};
      4'h2:    bus_rdata = t_now.min_o;
      4'h3:    bus_rdata = {1'b0, t_now.min_t};
      4'h4:    bus_rdata = t_now.hr_o;
      4'h5:    bus_rdata = {2'b00, t_now.hr_t};
      4'h6:    bus_rdata = {1'b0, t_now.wday};
      4'h7:    bus_rdata = t_now.day_o;
      4'h8:    bus_rdata = {2'b00, t_now.day_t};
      4'h9:    bus_rdata = t_now.mon_o;
      4'hA:    bus_rdata = {3'b000, t_now.mon_t};
      4'hB:    bus_rdata = t_now.yr[0];
      4'hC:    bus_rdata = t_now.yr[1];
      4'hD:    bus_rdata = t_now.yr[2];
      4'hE:    bus_rdata = {2'b00, t_now.yr_k};
      default: bus_rdata = {2'b00, stop_q, busy};
    endcase
  end

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
  import rtc_cal_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       osc_stop,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic [3:0] bus_wdata,
  input logic       sec_pulse,
  input logic       adj_pend,
  input logic       busy,
  input logic       fail_q,
  input rtc_time_t  t_now
);
  logic adj_rewrite;
  assign adj_rewrite = bus_we && bus_addr == CTL_ADDR && bus_wdata[0];

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !bus_we && t_now.sec_t == 3'd5 && t_now.sec_o == 4'd9)
    |=> (t_now.sec_t == 3'd0 && t_now.sec_o == 4'd0)); // R2

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !bus_we && t_now.sec_t == 3'd5 && t_now.sec_o == 4'd9 &&
     t_now.min_t == 3'd5 && t_now.min_o == 4'd9 && t_now.hr_t == 2'd2 &&
     t_now.hr_o == 4'd3 && t_now.wday == 3'd6) |=> (t_now.wday == 3'd0)); // R3

  AST_NO_COUNT_OUTSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_we) |=> $stable(t_now)); // R10

  AST_ADJ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_pend && ref_tick && !adj_rewrite) |=> !adj_pend); // R9

  AST_ADJ_ROUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_pend && ref_tick && !bus_we && t_now.sec_t < 3'd3)
    |=> (t_now.sec_t == 3'd0 && t_now.sec_o == 4'd0 && $stable(t_now.min_o))); // R7

  AST_ADJ_ROUND_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_pend && ref_tick && !bus_we && t_now.sec_t >= 3'd3 && t_now.min_o < 4'd9)
    |=> (t_now.sec_o == 4'd0 && t_now.min_o == $past(t_now.min_o) + 4'd1)); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> fail_q); // R13

endmodule

bind rtc_calendar_core rtc_calendar_core_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ref_tick (ref_tick),
  .osc_stop (osc_stop),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .sec_pulse(sec_pulse),
  .adj_pend (adj_pend),
  .busy     (busy),
  .fail_q   (fail_q),
  .t_now    (t_now)
);

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  localparam int TPS  = 64;
  localparam int BUSY = 8;
  localparam int SEC_WAIT = TPS * 4 + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       osc_stop = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [3:0] bus_wdata = 4'h0;
  logic [3:0] bus_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int n_ref = 0;
  logic [1:0] ph = 2'd0;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(BUSY)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_stop(osc_stop),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph <= ph + 2'd1;
    ref_tick <= (ph == 2'd3);
  end
  always @(posedge clk) if (ref_tick) n_ref <= n_ref + 1;

  task automatic chk(input string req, input logic [59:0] got, input logic [59:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [3:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // layout {year16, month8, date8, weekday4, hh8, mm8, ss8}: nibble at address a = v[4a+3:4a]
  task automatic set_dt(input logic [59:0] v);
    for (int a = 0; a < 15; a++) bus_write(4'(a), v[4*a +: 4]);
  endtask

  task automatic read_dt(output logic [59:0] v);
    logic [3:0] d;
    for (int a = 0; a < 15; a++) begin
      bus_read(4'(a), d);
      if (a == 1) d[3] = 1'b0;
      v[4*a +: 4] = d;
    end
  endtask

  task automatic t_reset;
    logic [59:0] v; logic [3:0] d;
    read_dt(v);
    chk("R1 reset time", v, {16'h2000, 8'h01, 8'h01, 4'h0, 24'h000000});
    bus_read(4'h1, d);
    chk("R1 reset fail flag", {59'd0, d[3]}, 60'd1);
    bus_read(4'hF, d);
    chk("R1 reset control", {56'd0, d}, 60'd0);
  endtask

  task automatic t_fail_and_map;
    logic [3:0] d;
    bus_write(4'hF, 4'b0010);
    bus_write(4'h1, 4'h0);
    bus_read(4'h1, d);
    chk("R13 fail cleared by 0", {59'd0, d[3]}, 60'd0);
    osc_stop = 1'b1; @(posedge clk); @(negedge clk); osc_stop = 1'b0;
    bus_read(4'h1, d);
    chk("R13 fail set by osc_stop", {59'd0, d[3]}, 60'd1);
    wait_clks(6);
    bus_read(4'h1, d);
    chk("R13 fail sticky", {59'd0, d[3]}, 60'd1);
    bus_write(4'h5, 4'hF);
    bus_read(4'h5, d);
    chk("R14 hour tens width", {56'd0, d}, 60'h3);
    bus_write(4'hE, 4'hF);
    bus_read(4'hE, d);
    chk("R14 thousands width", {56'd0, d}, 60'h3);
    bus_read(4'hF, d);
    chk("R14 R11 control readback", {56'd0, d}, 60'h2);
  endtask

  task automatic roll(input string req, input logic [59:0] start, input logic [59:0] exp);
    logic [59:0] v;
    bus_write(4'hF, 4'b0010);
    set_dt(start);
    bus_write(4'hF, 4'b0000);
    wait_clks(SEC_WAIT);
    read_dt(v);
    chk(req, v, exp);
  endtask

  task automatic t_busy_window;
    logic [3:0] d; logic [59:0] v; int n0; int rise_at; int fall_at;
    bus_write(4'hF, 4'b0010);
    set_dt({16'h2024, 8'h05, 8'h10, 4'h5, 24'h101007});
    bus_write(4'hF, 4'b0000);
    n0 = n_ref; rise_at = -1; fall_at = -1;
    for (int i = 0; i < 2000; i++) begin
      bus_read(4'hF, d);
      if (d[0]) begin rise_at = n_ref - n0; break; end
      @(negedge clk);
    end
    chk("R10 busy opens 8 ticks before update", 60'(rise_at), 60'(TPS - BUSY));
    read_dt(v);
    chk("R10 seconds unchanged inside window", v, {16'h2024, 8'h05, 8'h10, 4'h5, 24'h101007});
    for (int i = 0; i < 2000; i++) begin
      bus_read(4'hF, d);
      if (!d[0]) begin fall_at = n_ref - n0; break; end
      @(negedge clk);
    end
    chk("R10 R11 window closes at update", 60'(fall_at), 60'(TPS));
    read_dt(v);
    chk("R10 seconds updated at window end", v, {16'h2024, 8'h05, 8'h10, 4'h5, 24'h101008});
  endtask

  task automatic t_stop_hold;
    logic [59:0] a; logic [59:0] b; logic [3:0] d;
    wait_clks(20);
    bus_write(4'hF, 4'b0010);
    read_dt(a);
    wait_clks(3 * TPS * 4);
    read_dt(b);
    chk("R11 stop freezes time", b, a);
    bus_read(4'hF, d);
    chk("R11 stop bit reads back", {56'd0, d}, 60'h2);
  endtask

  task automatic t_adjust;
    logic [59:0] v; logic [3:0] d;
    bus_write(4'hF, 4'b0010);
    set_dt({16'h2024, 8'h06, 8'h01, 4'h6, 24'h121545});
    bus_write(4'hF, 4'b0010);
    wait_clks(12);
    read_dt(v);
    chk("R9 writing 0 to adjust has no effect", v, {16'h2024, 8'h06, 8'h01, 4'h6, 24'h121545});
    set_dt({16'h2024, 8'h06, 8'h01, 4'h6, 24'h121529});
    bus_write(4'hF, 4'b0011);
    bus_read(4'hF, d);
    chk("R9 busy while adjust waits", {56'd0, d}, 60'h3);
    wait_clks(8);
    bus_read(4'hF, d);
    chk("R9 adjust self-clears", {56'd0, d}, 60'h2);
    read_dt(v);
    chk("R7 round down at 29", v, {16'h2024, 8'h06, 8'h01, 4'h6, 24'h121500});
    set_dt({16'h2024, 8'h06, 8'h01, 4'h6, 24'h120530});
    bus_write(4'hF, 4'b0011);
    wait_clks(8);
    read_dt(v);
    chk("R8 round up at 30", v, {16'h2024, 8'h06, 8'h01, 4'h6, 24'h120600});
    set_dt({16'h2099, 8'h12, 8'h31, 4'h6, 24'h235945});
    bus_write(4'hF, 4'b0011);
    wait_clks(8);
    read_dt(v);
    chk("R8 R6 round up with full carry", v, {16'h2100, 8'h01, 8'h01, 4'h0, 24'h000000});
  endtask

  task automatic t_clash;
    logic [59:0] v; int n0;
    bus_write(4'hF, 4'b0010);
    set_dt({16'h2024, 8'h07, 8'h04, 4'h4, 24'h081059});
    bus_write(4'hF, 4'b0000);
    n0 = n_ref;
    for (int i = 0; i < 2000 && (n_ref - n0) < TPS - 1; i++) @(negedge clk);
    bus_write(4'hF, 4'b0001);
    wait_clks(8);
    read_dt(v);
    chk("R12 adjust and carry on one tick", v, {16'h2024, 8'h07, 8'h04, 4'h4, 24'h081100});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_clks(3);
    t_reset();
    t_fail_and_map();
    t_busy_window();
    t_stop_hold();
    roll("R2 R3 R5 leap Feb 28 to 29", {16'h2024, 8'h02, 8'h28, 4'h3, 24'h235959},
                                       {16'h2024, 8'h02, 8'h29, 4'h4, 24'h000000});
    roll("R5 leap Feb 29 to Mar 1",    {16'h2024, 8'h02, 8'h29, 4'h4, 24'h235959},
                                       {16'h2024, 8'h03, 8'h01, 4'h5, 24'h000000});
    roll("R4 non-leap Feb 28 to Mar 1", {16'h2023, 8'h02, 8'h28, 4'h2, 24'h235959},
                                        {16'h2023, 8'h03, 8'h01, 4'h3, 24'h000000});
    roll("R4 30-day month end",        {16'h2024, 8'h04, 8'h30, 4'h2, 24'h235959},
                                       {16'h2024, 8'h05, 8'h01, 4'h3, 24'h000000});
    roll("R2 minute carry",            {16'h2024, 8'h09, 8'h15, 4'h0, 24'h104559},
                                       {16'h2024, 8'h09, 8'h15, 4'h0, 24'h104600});
    roll("R6 R3 year end 2099",        {16'h2099, 8'h12, 8'h31, 4'h6, 24'h235959},
                                       {16'h2100, 8'h01, 8'h01, 4'h0, 24'h000000});
    t_adjust();
    t_clash();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule